// File: doc/BRIEF.md
# H-Bridge Command Decoder and Fault Manager

This block sits between the logic pins of a two-leg H-bridge and its four power-switch gate drivers. A pair of direction inputs selects the level of each leg: forward, reverse, or a dynamic brake through both high-side or both low-side switches. Two disable inputs of opposite polarity, an enable input with a sleep state, and three protection flags (undervoltage, short circuit and overtemperature) can force all four switches off.

Every external input passes through a two-flop synchronizer. Undervoltage holds the bridge off only while it is present. Short-circuit and overtemperature faults latch, and they are released only by an edge on either disable input. Each such edge also produces a one-cycle clear pulse for the protection latches. A wake-up interval follows each rise of enable. A break-before-make gap inside each leg keeps its two switches from ever conducting together. The fault output is an open-drain pull-down enable: when it is high, the fault status line is pulled low.

Top module: `hbridge_cmd`

## Requirements
- R1: With the bridge awake, enabled and fault-free, `dir_a_i`=1 turns on only `a_hi_o` and `dir_a_i`=0 turns on only `a_lo_o`. Leg B follows `dir_b_i` in the same way, independently of leg A.
- R2: Equal direction inputs brake the motor. Both at 1 turns on `a_hi_o` and `b_hi_o`; both at 0 turns on `a_lo_o` and `b_lo_o`.
- R3: `dis_hi_i`=1 or `dis_lo_n_i`=0 turns all four gates off. The fault logic keeps working while the bridge is disabled.
- R4: `en_i`=0 turns all gates off. After the synchronized enable rises, the gates stay off for WAKE_CYCLES clock cycles. The count restarts whenever enable falls.
- R5: Reset loads the input synchronizers with the sleep and disabled levels (enable 0, `dis_hi_i` 1, `dis_lo_n_i` 0). After reset, all gates are off and `fault_pd_o` and `latch_clr_o` are 0.
- R6: While undervoltage is flagged, all gates are off and `fault_pd_o`=1. When the flag drops, `fault_pd_o` returns to 0 and the gates resume as the inputs dictate, with no disable toggle needed.
- R7: A short-circuit or overtemperature flag, even a short one, latches: the gates stay off and `fault_pd_o`=1 after the flag drops. The latch is released only by an edge on either synchronized disable input that occurs while both flags are low.
- R8: Every edge on a synchronized disable input, rising or falling, produces a one-cycle pulse on `latch_clr_o`.
- R9: The two gates of one leg are never on together. Once either gate of a leg turns off, both gates of that leg stay off for at least DEAD_CYCLES+1 cycles before either turns on.
- R10: A change on an input pin reaches `fault_pd_o` and `latch_clr_o` on the third rising clock edge after it is sampled. It reaches the gate outputs on the fourth edge, plus any dead-time wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; 0 puts the bridge to sleep |
| dir_a_i | input | 1 | Level request for leg A (1 = high side) |
| dir_b_i | input | 1 | Level request for leg B (1 = high side) |
| dis_hi_i | input | 1 | Disable, active high |
| dis_lo_n_i | input | 1 | Disable, active low |
| uv_i | input | 1 | Undervoltage flag from the supply comparator (the hysteresis is in the comparator) |
| short_i | input | 1 | Short-circuit detect flag |
| ot_i | input | 1 | Overtemperature flag |
| a_hi_o | output | 1 | Leg A high-side gate enable |
| a_lo_o | output | 1 | Leg A low-side gate enable |
| b_hi_o | output | 1 | Leg B high-side gate enable |
| b_lo_o | output | 1 | Leg B low-side gate enable |
| fault_pd_o | output | 1 | Open-drain pull-down enable for the active-low fault status |
| latch_clr_o | output | 1 | One-cycle clear pulse for the protection latches |

## Verification
A pin change is captured by two synchronizer edges. The control register acts on the third edge, so the fault output and the clear pulse change after three edges. The gates follow after four edges, and after four plus DEAD_CYCLES+1 edges when a leg has to reverse. After an enable rise, the gates come on after WAKE_CYCLES+3 edges. The bench keeps a behavioural reference of these delays, updated at each rising edge and compared with every output at each falling edge. Targeted checks then sample exactly one cycle before and at the edge where the latency, wake-up and dead-time results are due.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_req_e;

    typedef struct packed {
        logic en;
        logic dir_a;
        logic dir_b;
        logic dis_hi;
        logic dis_lo_n;
        logic uv;
        logic short_f;
        logic ot;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    localparam pins_t PINS_RESET = '{
        en: 1'b0, dir_a: 1'b0, dir_b: 1'b0, dis_hi: 1'b1,
        dis_lo_n: 1'b0, uv: 1'b0, short_f: 1'b0, ot: 1'b0
    };

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int              WIDTH   = 8,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] stage_d;
            if (s == 0) begin : g_first
                assign stage_d = din;
            end else begin : g_next
                assign stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d;
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hb_fault.sv
module hb_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic d_hi_s,
    input  logic d_lo_n_s,
    input  logic uv_s,
    input  logic short_s,
    input  logic ot_s,
    output logic hold_off,
    output logic fault_o,
    output logic clr_o
);
    typedef struct packed {
        logic prev_hi;
        logic prev_lo_n;
        logic latch;
        logic clr;
        logic fault;
    } fst_t;

    fst_t st_d, st_q;
    logic toggle;

    always_comb begin
        toggle         = (d_hi_s ^ st_q.prev_hi) | (d_lo_n_s ^ st_q.prev_lo_n);
        st_d.prev_hi   = d_hi_s;
        st_d.prev_lo_n = d_lo_n_s;
        st_d.latch     = short_s | ot_s | (st_q.latch & ~toggle);
        st_d.clr       = toggle;
        st_d.fault     = uv_s | st_d.latch;
        hold_off       = st_d.latch | uv_s | d_hi_s | ~d_lo_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev_hi: 1'b1, prev_lo_n: 1'b0, latch: 1'b0, clr: 1'b0, fault: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.fault;
    assign clr_o   = st_q.clr;

    p_uv_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> fault_o);

    p_latch_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch && $stable(d_hi_s) && $stable(d_lo_n_s)) |=> (st_q.latch && fault_o));

    p_clr_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o && !toggle) |=> !clr_o);
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hbridge_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_e req,
    output logic     gate_hi,
    output logic     gate_lo
);
    localparam int DCNT_W = $clog2(DEAD_CYCLES + 1);

    typedef struct packed {
        logic              hi;
        logic              lo;
        logic [DCNT_W-1:0] dcnt;
    } leg_t;

    leg_t lg_d, lg_q;
    logic want_hi, want_lo;

    always_comb begin
        want_hi = (req == LEG_HI);
        want_lo = (req == LEG_LO);
        lg_d    = lg_q;
        if ((lg_q.hi && !want_hi) || (lg_q.lo && !want_lo)) begin
            lg_d.hi   = 1'b0;
            lg_d.lo   = 1'b0;
            lg_d.dcnt = DCNT_W'(DEAD_CYCLES);
        end else if (!lg_q.hi && !lg_q.lo) begin
            if (lg_q.dcnt != '0) begin
                lg_d.dcnt = lg_q.dcnt - 1'b1;
            end else begin
                lg_d.hi = want_hi;
                lg_d.lo = want_lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lg_q <= '0;
        else        lg_q <= lg_d;
    end

    assign gate_hi = lg_q.hi;
    assign gate_lo = lg_q.lo;

    p_off_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req == LEG_OFF) |=> (!gate_hi && !gate_lo));

    p_dead_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_hi) || $fell(gate_lo)) |=> (!gate_hi && !gate_lo));

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));
endmodule

// File: rtl/hbridge_cmd.sv
module hbridge_cmd
    import hbridge_pkg::*;
#(
    parameter int WAKE_CYCLES = 1000,
    parameter int DEAD_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic dir_a_i,
    input  logic dir_b_i,
    input  logic dis_hi_i,
    input  logic dis_lo_n_i,
    input  logic uv_i,
    input  logic short_i,
    input  logic ot_i,
    output logic a_hi_o,
    output logic a_lo_o,
    output logic b_hi_o,
    output logic b_lo_o,
    output logic fault_pd_o,
    output logic latch_clr_o
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam int LEGS  = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             awake;
        leg_req_e         req_a;
        leg_req_e         req_b;
    } ctl_t;

    pins_t raw, syn;
    ctl_t  ct_d, ct_q;
    logic  hold_off;
    logic  go;
    leg_req_e leg_req [LEGS];
    logic  [LEGS-1:0] g_hi, g_lo;

    assign raw = '{en: en_i, dir_a: dir_a_i, dir_b: dir_b_i, dis_hi: dis_hi_i,
                   dis_lo_n: dis_lo_n_i, uv: uv_i, short_f: short_i, ot: ot_i};

    hb_sync #(.WIDTH(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_RESET)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (syn)
    );

    hb_fault u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_hi_s  (syn.dis_hi),
        .d_lo_n_s(syn.dis_lo_n),
        .uv_s    (syn.uv),
        .short_s (syn.short_f),
        .ot_s    (syn.ot),
        .hold_off(hold_off),
        .fault_o (fault_pd_o),
        .clr_o   (latch_clr_o)
    );

    always_comb begin
        ct_d = ct_q;
        if (!syn.en) begin
            ct_d.cnt   = '0;
            ct_d.awake = 1'b0;
        end else if (ct_q.awake || ct_q.cnt == CNT_W'(WAKE_CYCLES - 1)) begin
            ct_d.awake = 1'b1;
        end else begin
            ct_d.cnt   = ct_q.cnt + 1'b1;
            ct_d.awake = 1'b0;
        end
        go         = ct_d.awake & ~hold_off;
        ct_d.req_a = !go ? LEG_OFF : (syn.dir_a ? LEG_HI : LEG_LO);
        ct_d.req_b = !go ? LEG_OFF : (syn.dir_b ? LEG_HI : LEG_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '{cnt: '0, awake: 1'b0, req_a: LEG_OFF, req_b: LEG_OFF};
        else        ct_q <= ct_d;
    end

    assign leg_req[0] = ct_q.req_a;
    assign leg_req[1] = ct_q.req_b;

    generate
        for (genvar l = 0; l < LEGS; l++) begin : g_leg
            hb_leg #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
                .clk    (clk),
                .rst_n  (rst_n),
                .req    (leg_req[l]),
                .gate_hi(g_hi[l]),
                .gate_lo(g_lo[l])
            );
        end
    endgenerate

    assign a_hi_o = g_hi[0];
    assign a_lo_o = g_lo[0];
    assign b_hi_o = g_hi[1];
    assign b_lo_o = g_lo[1];

    p_sleep_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !syn.en |=> (ct_q.req_a == LEG_OFF && ct_q.req_b == LEG_OFF && !ct_q.awake));

    p_fault_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pd_o |-> (ct_q.req_a == LEG_OFF && ct_q.req_b == LEG_OFF));
endmodule

// File: tb/sim_hbridge_cmd.sv
module sim_hbridge_cmd;
    localparam int W = 40;
    localparam int D = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic en = 0, da = 0, db = 0, d1 = 1, d2n = 0, uv = 0, sh = 0, ot = 0;
    logic a_hi, a_lo, b_hi, b_lo, fpd, clr;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R5";

    always #10 clk = ~clk;

    hbridge_cmd #(.WAKE_CYCLES(W), .DEAD_CYCLES(D)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .dir_a_i(da), .dir_b_i(db),
        .dis_hi_i(d1), .dis_lo_n_i(d2n), .uv_i(uv), .short_i(sh), .ot_i(ot),
        .a_hi_o(a_hi), .a_lo_o(a_lo), .b_hi_o(b_hi), .b_lo_o(b_lo),
        .fault_pd_o(fpd), .latch_clr_o(clr)
    );

    // Behavioural reference: bit order en,da,db,d1,d2n,uv,sh,ot (7..0)
    logic [7:0] m_s1 = 8'b0001_0000, m_s2 = 8'b0001_0000;
    bit m_pd1 = 1, m_pd2 = 0, m_latch = 0, m_clr = 0, m_fault = 0, m_awake = 0;
    int m_cnt = 0;
    int m_req [2] = '{0, 0};
    bit m_hi [2] = '{0, 0};
    bit m_lo [2] = '{0, 0};
    int m_dc [2] = '{0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 8'b0001_0000; m_s2 = 8'b0001_0000;
            m_pd1 = 1; m_pd2 = 0; m_latch = 0; m_clr = 0; m_fault = 0;
            m_awake = 0; m_cnt = 0;
            for (int l = 0; l < 2; l++) begin
                m_req[l] = 0; m_hi[l] = 0; m_lo[l] = 0; m_dc[l] = 0;
            end
        end else begin
            bit s_en, s_a, s_b, s_d1, s_d2, s_uv, s_sh, s_ot, tog, nl, aw, go;
            for (int l = 0; l < 2; l++) begin
                if ((m_hi[l] && m_req[l] != 1) || (m_lo[l] && m_req[l] != 2)) begin
                    m_hi[l] = 0; m_lo[l] = 0; m_dc[l] = D;
                end else if (!m_hi[l] && !m_lo[l]) begin
                    if (m_dc[l] > 0) m_dc[l] = m_dc[l] - 1;
                    else begin
                        m_hi[l] = (m_req[l] == 1);
                        m_lo[l] = (m_req[l] == 2);
                    end
                end
            end
            {s_en, s_a, s_b, s_d1, s_d2, s_uv, s_sh, s_ot} = m_s2;
            tog = (s_d1 != m_pd1) || (s_d2 != m_pd2);
            nl = s_sh || s_ot || (m_latch && !tog);
            aw = s_en && (m_awake || m_cnt == W - 1);
            if (!s_en) m_cnt = 0;
            else if (!aw) m_cnt = m_cnt + 1;
            m_awake = aw;
            go = aw && !(s_d1 || !s_d2 || s_uv || nl);
            m_req[0] = go ? (s_a ? 1 : 2) : 0;
            m_req[1] = go ? (s_b ? 1 : 2) : 0;
            m_latch = nl; m_fault = s_uv || nl; m_clr = tog;
            m_pd1 = s_d1; m_pd2 = s_d2;
            m_s2 = m_s1;
            m_s1 = {en, da, db, d1, d2n, uv, sh, ot};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [5:0] act, exp_v;
            act = {a_hi, a_lo, b_hi, b_lo, fpd, clr};
            exp_v = {m_hi[0], m_lo[0], m_hi[1], m_lo[1], m_fault, m_clr};
            n_chk++;
            if (act !== exp_v) begin
                n_fail++;
                $display("FAIL %s model compare at %0t: actual %b expected %b",
                         cur_req, $time, act, exp_v);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_gates(input string rq, input logic [3:0] exp_g);
        n_chk++;
        if ({a_hi, a_lo, b_hi, b_lo} !== exp_g) begin
            n_fail++;
            $display("FAIL %s gates actual %b expected %b", rq, {a_hi, a_lo, b_hi, b_lo}, exp_g);
        end
    endtask

    task automatic chk_fault(input string rq, input logic exp_f);
        n_chk++;
        if (fpd !== exp_f) begin
            n_fail++;
            $display("FAIL %s fault_pd actual %b expected %b", rq, fpd, exp_f);
        end
    endtask

    task automatic chk_clr_count(input string rq, input int cycles, input int exp_n);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            tick(1);
            if (clr) seen++;
        end
        n_chk++;
        if (seen != exp_n) begin
            n_fail++;
            $display("FAIL %s clear pulses actual %0d expected %0d", rq, seen, exp_n);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1;
        tick(1);
        // R5: reset state
        chk_gates("R5", 4'b0000);
        chk_fault("R5", 1'b0);
        n_chk++;
        if (clr !== 1'b0) begin n_fail++; $display("FAIL R5 clr actual %b expected 0", clr); end

        // R4: wake-up interval
        cur_req = "R4";
        d1 = 0; d2n = 1; da = 1; db = 0;
        tick(20);
        en = 1;
        tick(W + 2);
        chk_gates("R4", 4'b0000);
        tick(1);
        chk_gates("R4", 4'b1001);

        // R1 and R9: reversal with dead time
        cur_req = "R1";
        tick(5);
        da = 0; db = 1;
        tick(4);
        chk_gates("R9", 4'b0000);
        tick(D);
        chk_gates("R9", 4'b0000);
        tick(1);
        chk_gates("R1", 4'b0110);
        da = 1; db = 1;
        cur_req = "R2";
        tick(15);
        chk_gates("R2", 4'b1010);
        da = 0; db = 0;
        tick(15);
        chk_gates("R2", 4'b0101);
        da = 1; db = 0;
        tick(15);
        chk_gates("R1", 4'b1001);

        // R3, R8, R10: disable paths and latency
        cur_req = "R3";
        d1 = 1;
        tick(3);
        chk_gates("R10", 4'b1001);
        tick(1);
        chk_gates("R3", 4'b0000);
        d1 = 0;
        tick(15);
        d2n = 0;
        tick(10);
        chk_gates("R3", 4'b0000);
        d2n = 1;
        chk_clr_count("R8", 15, 1);
        chk_gates("R3", 4'b1001);

        // R6 and R10: undervoltage with self-recovery
        cur_req = "R6";
        uv = 1;
        tick(2);
        chk_fault("R10", 1'b0);
        tick(1);
        chk_fault("R6", 1'b1);
        tick(5);
        chk_gates("R6", 4'b0000);
        uv = 0;
        tick(15);
        chk_fault("R6", 1'b0);
        chk_gates("R6", 4'b1001);

        // R7: short circuit latch, cleared by an edge on the active-low disable
        cur_req = "R7";
        sh = 1; tick(2); sh = 0;
        tick(20);
        chk_fault("R7", 1'b1);
        chk_gates("R7", 4'b0000);
        d2n = 0;
        chk_clr_count("R8", 10, 1);
        chk_fault("R7", 1'b0);
        d2n = 1;
        tick(15);
        chk_gates("R7", 4'b1001);

        // R7: overtemperature still present during a toggle keeps the latch
        ot = 1;
        tick(6);
        d1 = 1; tick(6); d1 = 0;
        tick(10);
        chk_fault("R7", 1'b1);
        chk_gates("R7", 4'b0000);
        ot = 0;
        tick(10);
        chk_fault("R7", 1'b1);
        d1 = 1; tick(6); d1 = 0;
        tick(15);
        chk_fault("R7", 1'b0);
        chk_gates("R7", 4'b1001);

        // R4: sleep and restart of the wake count
        cur_req = "R4";
        en = 0;
        tick(6);
        chk_gates("R4", 4'b0000);
        en = 1; tick(10); en = 0; tick(5); en = 1;
        tick(W + 2);
        chk_gates("R4", 4'b0000);
        tick(1);
        chk_gates("R4", 4'b1001);
        tick(5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule